// File: doc/BRIEF.md
# Systolic Matrix-Multiply Issue Timing Tracker

This block models when matrix-multiply operations run on a weight-stationary systolic array. The array itself is not modelled, only its timing. An issuing agent offers one operation per cycle. Each operation carries a row count, a flag saying whether the operation first loads new weights into the array, and a destination tag. When an operation is accepted, the block works out its start cycle and its finish cycle and places it in an in-order completion queue.

A free-running cycle counter runs beside the queue. Every cycle the block compares the counter with the finish cycle of the oldest queued operation. When that operation is due, the block removes it and reports its tag on the completion output. The start cycle depends on three things: whether the queue is empty, whether the new operation loads weights, and the start cycle and row count of the most recently accepted operation. A weight load behind queued work overlaps that work. A weight load into an idle array pays the full load latency.

The array height and width and the queue depth are parameters. The block also counts accepted operations, and separately counts the accepted operations that load weights.

Top module: `gemm_issue_tracker`

## Requirements
- R1: After reset the cycle counter, the occupancy and both operation counters are zero, `done_valid_o` is low and `issue_ready_o` is high.
- R2: `now_o` increases by exactly one on every clock after reset.
- R3: A plain operation (`issue_preload_i`=0) accepted while the queue is empty has `issue_start_o` = `now_o`.
- R4: A weight-loading operation (`issue_preload_i`=1) accepted while the queue is empty has `issue_start_o` = `now_o` + 2*ARR_H - 1.
- R5: A plain operation accepted while the queue holds entries has `issue_start_o` = (start of the most recently accepted operation) + max(that operation's size, 4).
- R6: A weight-loading operation accepted while the queue holds entries has `issue_start_o` = (start of the most recently accepted operation) + ARR_H.
- R7: `issue_finish_o` = `issue_start_o` + ARR_H + ARR_W - 2 + max(`issue_size_i`, 4).
- R8: Only the oldest entry retires. It retires in the cycle where its finish cycle is less than or equal to `now_o`, at most one entry retires per cycle, and `done_tag_o` then carries its tag.
- R9: `issue_ready_o` is low exactly while DEPTH entries are queued. An offer made while ready is low is ignored: no entry is added and no counter changes.
- R10: An operation may be accepted in the same cycle as a retirement. If the retiring entry is the only one queued, the queue counts as empty for the start rule of the new operation.
- R11: `issue_cnt_o` increases by one for each accepted operation. `preload_cnt_o` increases by one for each accepted weight-loading operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Operation offered this cycle |
| issue_preload_i | input | 1 | Offered operation loads weights first |
| issue_size_i | input | SIZE_W | Row count of the offered operation |
| issue_tag_i | input | TAG_W | Destination tag of the offered operation |
| issue_ready_o | output | 1 | Queue can accept an operation |
| issue_start_o | output | TIME_W | Start cycle computed for the offered operation |
| issue_finish_o | output | TIME_W | Finish cycle computed for the offered operation |
| done_valid_o | output | 1 | Oldest entry retires this cycle |
| done_tag_o | output | TAG_W | Tag of the retiring entry |
| now_o | output | TIME_W | Free-running cycle counter |
| issue_cnt_o | output | STAT_W | Accepted operations |
| preload_cnt_o | output | STAT_W | Accepted weight-loading operations |

## Verification
The bench targets four faults. The first is an offer in the same cycle that the only queued entry retires: a design that still sees the queue as non-empty then chains the start cycle from a stale entry instead of starting at the current cycle. The second is row counts below four: a design that drops the floor of four produces short gaps and early finish cycles. The third is a weight load behind queued work: a design that applies the idle-array latency there returns a start cycle far too late. The fourth is overrun of a full queue and retirement order: offers made while the queue is full must leave the counters untouched, and a weight-loading entry that finishes before an older entry must still wait behind it, so an out-of-order design reports the wrong tag.

// File: rtl/gemm_track_pkg.sv
package gemm_track_pkg;
  localparam int unsigned MIN_ROWS = 4;

  function automatic logic [31:0] rows_floor(input logic [31:0] rows);
    return (rows < MIN_ROWS) ? 32'(MIN_ROWS) : rows;
  endfunction
endpackage

// File: rtl/gemm_cycle_ctr.sv
module gemm_cycle_ctr #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [TIME_W-1:0] now_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_o <= '0;
    else         now_o <= now_o + TIME_W'(1);
  end
endmodule

// File: rtl/gemm_slot_calc.sv
module gemm_slot_calc
  import gemm_track_pkg::*;
#(
  parameter int unsigned ARR_H  = 8,
  parameter int unsigned ARR_W  = 8,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned SIZE_W = 16
) (
  input  logic [TIME_W-1:0] now_i,
  input  logic              preload_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              q_empty_i,
  input  logic [TIME_W-1:0] last_start_i,
  input  logic [SIZE_W-1:0] last_size_i,
  output logic [TIME_W-1:0] start_o,
  output logic [TIME_W-1:0] finish_o
);
  localparam logic [TIME_W-1:0] FILL_DRAIN = TIME_W'(ARR_H + ARR_W - 2);
  localparam logic [TIME_W-1:0] LOAD_IDLE  = TIME_W'(2 * ARR_H - 1);
  localparam logic [TIME_W-1:0] LOAD_HIDE  = TIME_W'(ARR_H);

  logic [TIME_W-1:0] own_rows, last_rows;

  assign own_rows  = TIME_W'(rows_floor(32'(size_i)));
  assign last_rows = TIME_W'(rows_floor(32'(last_size_i)));

  always_comb begin
    if (q_empty_i) start_o = preload_i ? now_i + LOAD_IDLE : now_i;
    else           start_o = last_start_i + (preload_i ? LOAD_HIDE : last_rows);
    finish_o = start_o + FILL_DRAIN + own_rows;
  end
endmodule

// File: rtl/gemm_done_fifo.sv
module gemm_done_fifo #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 40,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [OCC_W-1:0]  occ_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign head_o  = mem_q[rd_q];
  assign empty_o = (occ_o == '0);
  assign full_o  = (occ_o == OCC_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      occ_o <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      if (push_i && !pop_i)      occ_o <= occ_o + OCC_W'(1);
      else if (pop_i && !push_i) occ_o <= occ_o - OCC_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
  end
endmodule

// File: rtl/gemm_issue_tracker.sv
module gemm_issue_tracker #(
  parameter int unsigned ARR_H  = 8,
  parameter int unsigned ARR_W  = 8,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic              issue_preload_i,
  input  logic [SIZE_W-1:0] issue_size_i,
  input  logic [TAG_W-1:0]  issue_tag_i,
  output logic              issue_ready_o,
  output logic [TIME_W-1:0] issue_start_o,
  output logic [TIME_W-1:0] issue_finish_o,
  output logic              done_valid_o,
  output logic [TAG_W-1:0]  done_tag_o,
  output logic [TIME_W-1:0] now_o,
  output logic [STAT_W-1:0] issue_cnt_o,
  output logic [STAT_W-1:0] preload_cnt_o
);
  localparam int unsigned ENT_W = TAG_W + TIME_W;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  logic              fire, q_empty, q_full, q_empty_eff;
  logic [OCC_W-1:0]  occ;
  logic [ENT_W-1:0]  head;
  logic [TIME_W-1:0] head_finish, last_start_q;
  logic [SIZE_W-1:0] last_size_q;

  gemm_cycle_ctr #(.TIME_W(TIME_W)) i_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .now_o(now_o)
  );

  gemm_done_fifo #(.DEPTH(DEPTH), .DATA_W(ENT_W)) i_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (fire),
    .push_data_i({issue_tag_i, issue_finish_o}),
    .pop_i      (done_valid_o),
    .head_o     (head),
    .empty_o    (q_empty),
    .full_o     (q_full),
    .occ_o      (occ)
  );

  assign head_finish   = head[TIME_W-1:0];
  assign done_tag_o    = head[ENT_W-1:TIME_W];
  assign done_valid_o  = !q_empty && (head_finish <= now_o);
  assign issue_ready_o = !q_full;
  assign fire          = issue_valid_i && issue_ready_o;
  // the sole entry leaving this cycle frees the array for a fresh start
  assign q_empty_eff   = q_empty || (occ == OCC_W'(1) && done_valid_o);

  gemm_slot_calc #(
    .ARR_H(ARR_H), .ARR_W(ARR_W), .TIME_W(TIME_W), .SIZE_W(SIZE_W)
  ) i_calc (
    .now_i       (now_o),
    .preload_i   (issue_preload_i),
    .size_i      (issue_size_i),
    .q_empty_i   (q_empty_eff),
    .last_start_i(last_start_q),
    .last_size_i (last_size_q),
    .start_o     (issue_start_o),
    .finish_o    (issue_finish_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_start_q  <= '0;
      last_size_q   <= '0;
      issue_cnt_o   <= '0;
      preload_cnt_o <= '0;
    end else if (fire) begin
      last_start_q <= issue_start_o;
      last_size_q  <= issue_size_i;
      issue_cnt_o  <= issue_cnt_o + STAT_W'(1);
      if (issue_preload_i) preload_cnt_o <= preload_cnt_o + STAT_W'(1);
    end
  end
endmodule

// File: rtl/gemm_issue_tracker_chk.sv
module gemm_issue_tracker_chk #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned STAT_W = 32,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_valid_i,
  input logic              issue_preload_i,
  input logic              issue_ready_o,
  input logic [TIME_W-1:0] issue_start_o,
  input logic [TIME_W-1:0] issue_finish_o,
  input logic              done_valid_o,
  input logic [TIME_W-1:0] now_o,
  input logic [STAT_W-1:0] issue_cnt_o,
  input logic [STAT_W-1:0] preload_cnt_o,
  input logic [OCC_W-1:0]  occ
);
  logic fire;
  assign fire = issue_valid_i && issue_ready_o;

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= OCC_W'(DEPTH));

  assert_refused_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && !issue_ready_o) |=> issue_cnt_o == $past(issue_cnt_o));

  assert_cycle_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> now_o == $past(now_o) + TIME_W'(1));

  assert_finish_late_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> issue_finish_o > issue_start_o);

  assert_retire_needs_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |-> occ != '0);

  assert_occ_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_o && !fire) |=> occ == $past(occ) - OCC_W'(1));

  assert_occ_both_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_o && fire) |=> occ == $past(occ));

  assert_issue_count_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> issue_cnt_o == $past(issue_cnt_o) + STAT_W'(1));

  assert_preload_count_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && issue_preload_i) |=> preload_cnt_o == $past(preload_cnt_o) + STAT_W'(1));
endmodule

bind gemm_issue_tracker gemm_issue_tracker_chk #(
  .DEPTH(DEPTH), .TIME_W(TIME_W), .STAT_W(STAT_W)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .issue_valid_i  (issue_valid_i),
  .issue_preload_i(issue_preload_i),
  .issue_ready_o  (issue_ready_o),
  .issue_start_o  (issue_start_o),
  .issue_finish_o (issue_finish_o),
  .done_valid_o   (done_valid_o),
  .now_o          (now_o),
  .issue_cnt_o    (issue_cnt_o),
  .preload_cnt_o  (preload_cnt_o),
  .occ            (occ)
);

// File: tb/test_gemm_issue_tracker.sv
`timescale 1ns/1ps
module test_gemm_issue_tracker;
  localparam int ARR_H = 8, ARR_W = 8, DEPTH = 4;
  localparam int TIME_W = 32, SIZE_W = 16, TAG_W = 8, STAT_W = 32;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic issue_valid_i = 1'b0, issue_preload_i = 1'b0;
  logic [SIZE_W-1:0] issue_size_i = '0;
  logic [TAG_W-1:0]  issue_tag_i = '0;
  logic issue_ready_o, done_valid_o;
  logic [TIME_W-1:0] issue_start_o, issue_finish_o, now_o;
  logic [TAG_W-1:0]  done_tag_o;
  logic [STAT_W-1:0] issue_cnt_o, preload_cnt_o;

  always #5 clk_i = ~clk_i;

  gemm_issue_tracker #(
    .ARR_H(ARR_H), .ARR_W(ARR_W), .DEPTH(DEPTH), .TIME_W(TIME_W),
    .SIZE_W(SIZE_W), .TAG_W(TAG_W), .STAT_W(STAT_W)
  ) i_gemm_issue_tracker (.*);

  int errors = 0, checks = 0, tb_cycles = 0;
  longint m_now = 0, m_last_start = 0, m_last_size = 0, m_cnt = 0, m_pre = 0;
  longint q_fin[$];
  int     q_tag[$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at model cycle %0d", req, act, exp, m_now);
    end
  endtask

  function automatic longint fl4(input longint v);
    return (v < 4) ? 4 : v;
  endfunction

  // caller is at a negedge; drives, checks, crosses one posedge, returns at next negedge
  task automatic step(input bit v, input bit p, input int sz, input int tg);
    bit due, rdy, fire, emp;
    longint st, fin;
    issue_valid_i = v; issue_preload_i = p;
    issue_size_i = SIZE_W'(sz); issue_tag_i = TAG_W'(tg);
    #1;
    due  = q_fin.size() > 0 && q_fin[0] <= m_now;
    rdy  = q_fin.size() < DEPTH;
    fire = v && rdy;
    chk(now_o == TIME_W'(m_now), "R2 cycle counter", now_o, m_now);
    chk(issue_ready_o == rdy, "R9 ready", issue_ready_o, rdy);
    chk(done_valid_o == due, "R8 retire", done_valid_o, due);
    if (due) chk(done_tag_o == TAG_W'(q_tag[0]), "R8 tag", done_tag_o, q_tag[0]);
    chk(issue_cnt_o == STAT_W'(m_cnt), "R11 issue count", issue_cnt_o, m_cnt);
    chk(preload_cnt_o == STAT_W'(m_pre), "R11 preload count", preload_cnt_o, m_pre);
    if (fire) begin
      emp = q_fin.size() == 0 || (q_fin.size() == 1 && due);
      if (emp && !p)       st = m_now;
      else if (emp)        st = m_now + 2 * ARR_H - 1;
      else if (!p)         st = m_last_start + fl4(m_last_size);
      else                 st = m_last_start + ARR_H;
      fin = st + ARR_H + ARR_W - 2 + fl4(sz);
      if (emp && q_fin.size() == 1)
        chk(issue_start_o == TIME_W'(st), "R10 start on sole retire", issue_start_o, st);
      else if (emp && !p) chk(issue_start_o == TIME_W'(st), "R3 start", issue_start_o, st);
      else if (emp)       chk(issue_start_o == TIME_W'(st), "R4 start", issue_start_o, st);
      else if (!p)        chk(issue_start_o == TIME_W'(st), "R5 start", issue_start_o, st);
      else                chk(issue_start_o == TIME_W'(st), "R6 start", issue_start_o, st);
      chk(issue_finish_o == TIME_W'(fin), "R7 finish", issue_finish_o, fin);
    end
    @(posedge clk_i);
    if (due) begin void'(q_fin.pop_front()); void'(q_tag.pop_front()); end
    if (fire) begin
      q_fin.push_back(fin); q_tag.push_back(tg);
      m_last_start = st; m_last_size = sz;
      m_cnt++; if (p) m_pre++;
    end
    m_now++;
    @(negedge clk_i);
  endtask

  task automatic drain();
    while (q_fin.size() > 0) step(0, 0, 0, 0);
  endtask

  // idle until the sole queued entry is due, then offer in that cycle
  task automatic issue_on_sole_retire(input bit p, input int sz, input int tg);
    while (!(q_fin.size() == 1 && q_fin[0] <= m_now)) step(0, 0, 0, 0);
    step(1, p, sz, tg);
  endtask

  always @(posedge clk_i) begin
    tb_cycles++;
    if (tb_cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(now_o == '0, "R1 counter reset", now_o, 0);
    chk(done_valid_o == 1'b0, "R1 no retire", done_valid_o, 0);
    chk(issue_ready_o == 1'b1, "R1 ready", issue_ready_o, 1);
    chk(issue_cnt_o == '0 && preload_cnt_o == '0, "R1 counts", issue_cnt_o, 0);
    @(negedge clk_i);
    m_now = 1;

    step(1, 0, 2, 1); drain();                      // R3, R7 size floor
    step(1, 1, 10, 2); drain();                     // R4
    step(1, 0, 3, 3); step(1, 0, 7, 4);             // R5
    step(1, 1, 5, 5); step(1, 0, 12, 6);            // R6
    drain();
    for (int i = 0; i < DEPTH + 3; i++) step(1, i[0], 40, 10 + i);  // R9 full
    drain();
    step(1, 0, 30, 20); step(1, 1, 1, 21); drain(); // R8 in-order retire
    step(1, 0, 20, 30); issue_on_sole_retire(0, 5, 31); drain();  // R10
    step(1, 0, 9, 32);  issue_on_sole_retire(1, 6, 33); drain();  // R10 preload
    step(1, 0, 25, 34); step(1, 0, 2, 35);
    while (!(q_fin.size() == 2 && q_fin[0] <= m_now)) step(0, 0, 0, 0);
    step(1, 0, 8, 36); drain();                     // R5 with one of two retiring
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], lfsr[2], int'(lfsr[8:3]), int'(lfsr[15:9]));
    end
    drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule